// File: doc/BRIEF.md
# Cascaded Interrupt Priority Encoder

This block gathers interrupt requests from three tiers (critical, main and peripheral) and a 32-channel DMA group that sits below the peripheral tier. It condenses them into a single encoded status word. Each tier has its own fixed-priority encoder, in which the lowest-numbered unmasked request wins. Each tier's winner and a valid flag are placed in a separate field of the status word. Some source codes do not stand for a request line. They are reserved to show that the real source is found in a lower tier. Main code 4 means "look at the peripheral field", and peripheral code 0 means "look at the DMA pending register".

A processor reads the status word through a small single-cycle register port. It tests the critical, then the main, then the peripheral valid flag, and follows any cascade code downward. When the peripheral field reports the DMA cascade, software reads the DMA pending register, takes its lowest set bit as the channel, and clears that bit by writing a 1 to it. The interrupt output is high whenever any tier has a valid winner. Programmable per-source priority levels are not built, so every peripheral is treated as low priority. As a result, the high-priority peripheral path (critical code 2) is never raised.

Top module: `irq_cascade_enc`

## Requirements
- R1: After reset the status word reads 0 and `irq` is low when no request is active. The peripheral mask reads 0x7FFFFC00, the main mask reads 0x00010FFF, the DMA mask reads 0xFFFFFFFF and the DMA pending register reads 0.
- R2: Status bit 10 is set when any of critical requests 0, 1 or 3 is high, and bits 9:8 give the lowest such index. Critical requests have no mask.
- R3: Critical index 2 is reserved for the high-priority peripheral path. Input `crit_req[2]` has no effect, and code 2 is never reported.
- R4: Status bit 21 is set when an unmasked main source is pending, and bits 20:16 give the lowest such index. Main source n (0 to 16) is disabled by bit 16-n of the main mask register (address 2) when that bit is 1.
- R5: Main source 4 is the peripheral cascade. It is pending exactly when the peripheral field is valid, it is gated by main mask bit 12, and input `main_req[4]` has no effect.
- R6: Status bit 29 is set when an unmasked peripheral source is pending, and bits 28:24 give the lowest such index. Peripheral source n (0 to 21) is disabled by bit 31-n of the peripheral mask register (address 1) when that bit is 1.
- R7: Peripheral source 0 is the DMA cascade. It is pending when any DMA pending bit has its DMA mask bit clear, and input `per_req[0]` has no effect.
- R8: DMA pending bit n (address 4) is set by a cycle with `dma_req[n]` high and then holds. Writing 1 to bit n clears it, and writing 0 leaves it unchanged. If a set and a clear meet in the same cycle, the set wins.
- R9: DMA mask bit n (address 3) set to 1 keeps channel n out of the cascade, but the channel stays visible in the pending register.
- R10: `irq` is high exactly when status bit 10, 21 or 29 would read as 1, and it follows the requests combinationally.
- R11: Register map: address 0 is the status word, address 1 the peripheral mask, address 2 the main mask, address 3 the DMA mask and address 4 the DMA pending register. Writes to address 0 are ignored. Peripheral mask bits 9:0 and main mask bits 31:17 read 0. Addresses 5 to 7 read 0.
- R12: A read with `rd_en` high puts the addressed value on `rdata` one cycle later. The status value returned is the one seen in the read cycle, and `rdata` holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| crit_req | input | 4 | Critical tier requests (index 2 reserved) |
| main_req | input | N_MAIN (17) | Main tier requests (index 4 reserved) |
| per_req | input | N_PER (22) | Peripheral tier requests (index 0 reserved) |
| dma_req | input | 32 | DMA channel request pulses into the pending register |
| irq | output | 1 | Processor interrupt |

## Verification
Wrong state in this block shows up in only two places. The first is a mask or pending bit, which shows up on the next read of that register. The second is the status field that bit feeds, which shows up at `irq` in the same cycle. A mask bit stored at the wrong position shows up as the wrong tier index as soon as only that source is driven. For this reason the sweeps drive one source at a time, under each mask setting. A broken cascade is visible in two fields at once, because main code 4 and peripheral code 0 must appear together with the lower tier's valid flag.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_STAT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_PMASK = 3'd1;
  localparam logic [ADDR_W-1:0] A_MMASK = 3'd2;
  localparam logic [ADDR_W-1:0] A_DMASK = 3'd3;
  localparam logic [ADDR_W-1:0] A_DPEND = 3'd4;

  localparam int unsigned CRIT_RSV  = 2;
  localparam int unsigned MAIN_CASC = 4;
  localparam int unsigned PER_CASC  = 0;

  // register bit that gates source n when sources are laid out downward from top
  function automatic int unsigned mask_pos(int unsigned top, int unsigned n);
    return top - n;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(
    logic cv, logic [1:0] cn, logic mv, logic [4:0] mn, logic pv, logic [4:0] pn);
    logic [REG_W-1:0] s;
    s = '0;
    s[10]    = cv;
    s[9:8]   = cn;
    s[21]    = mv;
    s[20:16] = mn;
    s[29]    = pv;
    s[28:24] = pn;
    return s;
  endfunction
endpackage

// File: rtl/irq_cascade_prienc.sv
module irq_cascade_prienc #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vec,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  // winner is a live request (R2, R4, R6)
  p_winner_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> vec[idx]);
  // nothing below the winner is pending (R4, R6)
  p_lowest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((vec & ((N'(1) << idx) - N'(1))) == '0));
endmodule

// File: rtl/irq_cascade_dma.sv
module irq_cascade_dma #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] pend,
  output logic [N-1:0] mask,
  output logic         any
);
  logic [N-1:0] clr_bits;

  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '1;
    end else begin
      pend <= (pend & ~clr_bits) | req;
      if (mask_we) mask <= wdata;
    end
  end

  assign any = |(pend & ~mask);

  // written ones vanish unless re-requested (R8)
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pend & $past(wdata & ~req)) == '0));
  // without a clear, pending bits hold (R8)
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((pend & $past(pend)) == $past(pend)));
  // a request always lands, even against a clear (R8)
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |=> ((pend & $past(req)) == $past(req)));
endmodule

// File: rtl/irq_cascade_enc.sv
module irq_cascade_enc
  import irq_cascade_pkg::*;
#(
  parameter int unsigned N_MAIN = 17,
  parameter int unsigned N_PER  = 22,
  parameter int unsigned N_DMA  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [3:0]        crit_req,
  input  logic [N_MAIN-1:0] main_req,
  input  logic [N_PER-1:0]  per_req,
  input  logic [N_DMA-1:0]  dma_req,
  output logic              irq
);
  localparam int unsigned N_CRIT   = 4;
  localparam int unsigned MAIN_TOP = N_MAIN - 1;
  localparam int unsigned PER_TOP  = REG_W - 1;
  localparam int unsigned MIW      = $clog2(N_MAIN);
  localparam int unsigned PIW      = $clog2(N_PER);
  localparam logic [N_CRIT-1:0] CRIT_RSV_OH  = N_CRIT'(1) << CRIT_RSV;
  localparam logic [N_MAIN-1:0] MAIN_CASC_OH = N_MAIN'(1) << MAIN_CASC;
  localparam logic [N_PER-1:0]  PER_CASC_OH  = N_PER'(1) << PER_CASC;
  // reset: every peripheral but the DMA cascade off; main 1..4 on, rest off
  localparam logic [N_PER-1:0]  PMASK_RST = ~PER_CASC_OH;
  localparam logic [N_MAIN-1:0] MMASK_RST = ~N_MAIN'(5'b11110);

  // named internal events
  logic              wr_pmask, wr_mmask, wr_dmask, wr_dpend;
  logic [N_PER-1:0]  pmask_q, pmask_d;
  logic [N_MAIN-1:0] mmask_q, mmask_d;
  logic [31:0]       pmask_word, mmask_word, stat_w, rd_mux;
  logic [N_DMA-1:0]  dma_pend, dma_mask;
  logic              dma_any;
  logic [N_CRIT-1:0] crit_vec;
  logic [N_MAIN-1:0] main_vec;
  logic [N_PER-1:0]  per_vec;
  logic              crit_v, main_v, per_v;
  logic [1:0]        crit_n;
  logic [MIW-1:0]    main_n;
  logic [PIW-1:0]    per_n;

  assign wr_pmask = wr_en && (addr == A_PMASK);
  assign wr_mmask = wr_en && (addr == A_MMASK);
  assign wr_dmask = wr_en && (addr == A_DMASK);
  assign wr_dpend = wr_en && (addr == A_DPEND);

  // mask bit ordering: source n sits at top-n of its register
  always_comb begin
    pmask_word = '0;
    mmask_word = '0;
    for (int n = 0; n < int'(N_PER); n++) begin
      pmask_d[n] = wdata[mask_pos(PER_TOP, n)];
      pmask_word[mask_pos(PER_TOP, n)] = pmask_q[n];
    end
    for (int n = 0; n < int'(N_MAIN); n++) begin
      mmask_d[n] = wdata[mask_pos(MAIN_TOP, n)];
      mmask_word[mask_pos(MAIN_TOP, n)] = mmask_q[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmask_q <= PMASK_RST;
      mmask_q <= MMASK_RST;
    end else begin
      if (wr_pmask) pmask_q <= pmask_d;
      if (wr_mmask) mmask_q <= mmask_d;
    end
  end

  irq_cascade_dma #(.N(N_DMA)) u_dma (
    .clk(clk), .rst_n(rst_n), .req(dma_req),
    .clr_we(wr_dpend), .mask_we(wr_dmask), .wdata(wdata[N_DMA-1:0]),
    .pend(dma_pend), .mask(dma_mask), .any(dma_any)
  );

  // tier request vectors; reserved inputs are replaced by cascades
  assign crit_vec = crit_req & ~CRIT_RSV_OH;
  assign per_vec  = ((per_req & ~PER_CASC_OH) | (PER_CASC_OH & {N_PER{dma_any}})) & ~pmask_q;
  assign main_vec = ((main_req & ~MAIN_CASC_OH) | (MAIN_CASC_OH & {N_MAIN{per_v}})) & ~mmask_q;

  irq_cascade_prienc #(.N(N_CRIT), .IW(2)) u_crit (
    .clk(clk), .rst_n(rst_n), .vec(crit_vec), .valid(crit_v), .idx(crit_n));
  irq_cascade_prienc #(.N(N_MAIN), .IW(MIW)) u_main (
    .clk(clk), .rst_n(rst_n), .vec(main_vec), .valid(main_v), .idx(main_n));
  irq_cascade_prienc #(.N(N_PER), .IW(PIW)) u_per (
    .clk(clk), .rst_n(rst_n), .vec(per_vec), .valid(per_v), .idx(per_n));

  assign stat_w = pack_status(crit_v, crit_n, main_v, 5'(main_n), per_v, 5'(per_n));
  assign irq    = crit_v | main_v | per_v;

  always_comb begin
    case (addr)
      A_STAT:  rd_mux = stat_w;
      A_PMASK: rd_mux = pmask_word;
      A_MMASK: rd_mux = mmask_word;
      A_DMASK: rd_mux = REG_W'(dma_mask);
      A_DPEND: rd_mux = REG_W'(dma_pend);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  p_crit_rsv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    crit_v |-> (crit_n != 2'(CRIT_RSV)));
  p_main_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    main_v |-> ((main_n < MIW'(N_MAIN)) && !mmask_q[main_n]));
  p_casc_main_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (main_v && (main_n == MIW'(MAIN_CASC))) |-> per_v);
  p_per_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    per_v |-> ((per_n < PIW'(N_PER)) && !pmask_q[per_n]));
  p_casc_dma_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (per_v && (per_n == PIW'(PER_CASC))) |-> ((dma_pend & ~dma_mask) != '0));
  p_irq_field_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat_w & 32'h2020_0400) != '0));
  p_rd_stat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == A_STAT)) |=> (rdata == $past(stat_w)));
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/sim_irq_cascade_enc.sv
module sim_irq_cascade_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  cr = '0;
  logic [16:0] mr = '0;
  logic [21:0] pr = '0;
  logic [31:0] dq = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench shadows of the register words
  logic [31:0] pmw, mmw, dm, pend;
  localparam logic [31:0] PM_IMPL = 32'hFFFF_FC00;
  localparam logic [31:0] MM_IMPL = 32'h0001_FFFF;

  always #10 clk = ~clk;

  irq_cascade_enc u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .crit_req(cr), .main_req(mr),
    .per_req(pr), .dma_req(dq), .irq(irq));

  function automatic logic [31:0] model();
    int cn = -1, mn = -1, pn = -1;
    logic dany;
    logic [31:0] s;
    dany = (pend & ~dm) != 0;
    for (int i = 0; i < 4; i++) if (cn < 0 && i != 2 && cr[i]) cn = i;
    for (int i = 0; i < 22; i++) begin
      logic act;
      act = (i == 0) ? dany : pr[i];
      if (pn < 0 && act && !pmw[31 - i]) pn = i;
    end
    for (int i = 0; i < 17; i++) begin
      logic act;
      act = (i == 4) ? (pn >= 0) : mr[i];
      if (mn < 0 && act && !mmw[16 - i]) mn = i;
    end
    s = 0;
    if (cn >= 0) s = s + 32'h400 + 32'(cn * 256);
    if (mn >= 0) s = s + 32'h0020_0000 + (32'(mn) << 16);
    if (pn >= 0) s = s + 32'h2000_0000 + (32'(pn) << 24);
    return s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd1: pmw = d & PM_IMPL;
      3'd2: mmw = d & MM_IMPL;
      3'd3: dm = d;
      3'd4: pend = pend & ~d;
      default: ;
    endcase
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v, output logic irq_s);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    irq_s = irq;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic pulse(logic [31:0] m);
    @(negedge clk);
    dq = m;
    @(negedge clk);
    dq = '0;
    pend = pend | m;
  endtask

  // status plus irq against the model
  task automatic chk_stat(string req);
    logic [31:0] v, e;
    logic        i;
    e = model();
    rd(3'd0, v, i);
    check(req, v, e);
    check({req, " irq (R10)"}, 32'(i), 32'(e[29] | e[21] | e[10]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic        i;
    pmw = 32'h7FFF_FC00; mmw = 32'h0001_0FFF; dm = '1; pend = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v, i); check("R1 status", v, 0); check("R1 irq", 32'(i), 0);
    rd(3'd1, v, i); check("R1 pmask", v, 32'h7FFF_FC00);
    rd(3'd2, v, i); check("R1 mmask", v, 32'h0001_0FFF);
    rd(3'd3, v, i); check("R1 dmask", v, 32'hFFFF_FFFF);
    rd(3'd4, v, i); check("R1 dpend", v, 0);

    // R2 R3 critical exhaustive
    for (int k = 0; k < 16; k++) begin
      cr = 4'(k);
      chk_stat("R2 R3 critical");
    end
    cr = '0;

    // R4 main single sources under reset, open, closed masks
    for (int m = 0; m < 3; m++) begin
      if (m == 1) wr(3'd2, 32'h0);
      if (m == 2) wr(3'd2, 32'hFFFF_FFFF);
      for (int n = 0; n < 17; n++) begin
        mr = 17'(1) << n;
        chk_stat("R4 R5 main single");
      end
    end
    // R4 lowest unmasked wins: mask growing prefix of all-active sources
    mr = '1;
    for (int k = 0; k <= 17; k++) begin
      wr(3'd2, (32'h0001_FFFF << (17 - k)) & MM_IMPL);
      chk_stat("R4 lowest unmasked");
    end
    mr = '0;
    wr(3'd2, 32'h0001_0FFF);

    // R6 R7 R5 peripheral single sources, open mask then reset mask
    for (int m = 0; m < 2; m++) begin
      wr(3'd1, (m == 0) ? 32'h0 : 32'h7FFF_FC00);
      for (int n = 0; n < 22; n++) begin
        pr = 22'(1) << n;
        chk_stat("R6 R7 peripheral single");
      end
    end
    // R5 cascade gated by main mask bit 12
    wr(3'd1, 32'h0);
    pr = 22'h3FFFFE;
    wr(3'd2, 32'h0000_1000);
    chk_stat("R5 cascade masked");
    wr(3'd2, 32'h0001_0FFF);
    chk_stat("R5 cascade open");
    pr = '0;

    // R8 R7 DMA channels unmasked: set, cascade, W1C
    wr(3'd3, 32'h0);
    for (int c = 0; c < 32; c++) begin
      pulse(32'(1) << c);
      rd(3'd4, v, i); check("R8 pend set", v, pend);
      chk_stat("R7 dma cascade");
      wr(3'd4, 32'(1) << c);
      rd(3'd4, v, i); check("R8 pend w1c", v, pend);
    end
    // R8 write of zero keeps, set wins over same-cycle clear
    pulse(32'h0000_0120);
    wr(3'd4, 32'h0);
    rd(3'd4, v, i); check("R8 zero write keeps", v, 32'h0000_0120);
    @(negedge clk);
    dq = 32'h0000_0020; addr = 3'd4; wdata = 32'h0000_0120; wr_en = 1'b1;
    @(negedge clk);
    dq = '0; wr_en = 1'b0;
    pend = 32'h0000_0020;
    rd(3'd4, v, i); check("R8 set wins", v, 32'h0000_0020);
    // R9 masked channel visible but not cascaded
    wr(3'd3, 32'h0000_0020);
    rd(3'd4, v, i); check("R9 pend visible", v, 32'h0000_0020);
    chk_stat("R9 masked channel");
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);

    // combined tiers and R12 status follows inputs
    wr(3'd1, 32'h0);
    for (int k = 0; k < 8; k++) begin
      cr = 4'(k);
      mr = 17'(k * 3);
      pr = 22'(k * 5 + 2);
      chk_stat("R12 combined tiers");
    end
    cr = '0; mr = '0; pr = '0;
    chk_stat("R12 cleared");

    // R11 register map details
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v, i); check("R11 pmask impl bits", v, 32'hFFFF_FC00);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v, i); check("R11 mmask impl bits", v, 32'h0001_FFFF);
    wr(3'd0, 32'hFFFF_FFFF);
    chk_stat("R11 status write ignored");
    cr = 4'b0001;
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v, i); check("R11 unused address", v, 0);
    end
    // R12 rdata holds between reads
    repeat (3) @(negedge clk);
    check("R12 hold", rdata, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule